// File: doc/BRIEF.md
# Two-Wire Register Access Slave

This block sits on a two-wire serial control bus (clock line plus open-drain data line) and gives an external host read and write access to a bank of 16-bit registers. The registers are selected by an 8-bit index. The block syncs both bus lines to the system clock and finds start, repeated-start and stop conditions. It compares a 7-bit device identifier, returns acknowledges, and moves each 16-bit register word as two bytes, with the upper byte first.

A write sends the device identifier with the direction bit clear, then the register index, then one or more words. A read first sets the index the same way. The host then issues a repeated start and sends the identifier again with the direction bit set. The slave then shifts out words until the host declines a byte. The index steps by one after each complete word, so a single transfer can reach a run of consecutive registers. On the register side the block offers a plain port: an index, a write word with a one-cycle write strobe, and a read word that the register file returns for the current index.

Top module: `i2cRegSlave`

## Requirements
- R1: While reset is asserted, and in the cycle after, `sdaOe` is 0 and `regWe` is 0. After reset, `regAddr` reads 0x00.
- R2: After a start, the first byte holds a 7-bit identifier (most significant bit first) followed by a direction bit (0 = write, 1 = read). If the identifier equals `DEV_ID`, the slave acknowledges by holding `sdaOe` = 1 (data line low) through the ninth clock. If it differs, the slave gives no acknowledge and drives nothing until the next start.
- R3: After a matching identifier with direction 0, the next byte is taken most significant bit first as the register index. It is acknowledged and appears on `regAddr`.
- R4: The data bytes that follow are acknowledged one by one. After the second byte of a word, `regWe` pulses high for exactly one cycle. At that point `regWdata` holds {first byte, second byte} and `regAddr` holds the current index.
- R5: A stop that arrives after only the first byte of a word produces no `regWe`, and the register keeps its old value.
- R6: After each word written, the index increases by one, wrapping from 0xFF to 0x00.
- R7: A matching identifier with direction 1 makes the slave drive the word at the current index, upper byte first, each byte most significant bit first. A one-bit drives `sdaOe` = 0 and a zero-bit drives `sdaOe` = 1. If the read transfer has no preceding index byte, it uses the index left by the last transfer.
- R8: When the host acknowledges the lower byte of a word during a read, the index increases by one and the next word follows. When the host declines a byte, the slave releases the line and the index stays unchanged.
- R9: `sdaOe` changes only while the clock line is low.
- R10: A start or stop at any bit position drops the byte in progress. A start, including a repeated one, restarts identifier reception, so a complete transfer after an aborted one behaves normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaOe | output | 1 | 1 pulls the data line low, 0 releases it |
| regAddr | output | 8 | Current register index |
| regWdata | output | 16 | Word to write |
| regWe | output | 1 | One-cycle write strobe |
| regRdata | input | 16 | Register file contents at `regAddr` |

## Verification
The bench goes after the places where an off-by-one in the bit counter or the word pointer would show. Examples are a write at index 0xFF that must wrap to 0x00, a burst read whose last word is declined, and an address-less read that must reuse the leftover index. A design that commits on the first byte would corrupt the register in the truncated-write case. A design that acknowledges every identifier would show up in the foreign-address transfer. A design that keeps driving after a declined byte would show a driven line when it should be released. Aborting an index byte halfway with a repeated start checks that a stale bit count cannot leak into the next transfer.

// File: rtl/i2cRegPkg.sv
package i2cRegPkg;
  localparam int ADDR_W = 8;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int CNT_W  = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_REG, ST_WHI, ST_WLO, ST_RHI, ST_RLO, ST_SKIP
  } busState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftEn;
    logic loadAddr;
    logic latchHi;
    logic commitWr;
    logic incAddr;
    logic loadWord;
  } dpStrobe_t;

  // synchronized bus events from datapath to control
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startDet;
    logic stopDet;
    logic sdaBit;
  } busEvt_t;
endpackage

// File: rtl/i2cRegDatapath.sv
module i2cRegDatapath
  import i2cRegPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  input  dpStrobe_t          strobe,
  output busEvt_t            evt,
  output logic [BYTE_W-1:0]  rxByte,
  output logic [WORD_W-1:0]  rdWord,
  output logic [ADDR_W-1:0]  regAddr,
  output logic [WORD_W-1:0]  regWdata,
  output logic               regWe,
  input  logic [WORD_W-1:0]  regRdata
);
  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclPrev, sdaPrev, sclNow, sdaNow;
  logic [BYTE_W-1:0] hiByte;
  logic [ADDR_W-1:0] addrPtr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  assign sclNow = sclSync[SYNC_STAGES-1];
  assign sdaNow = sdaSync[SYNC_STAGES-1];

  always_comb begin
    evt.sclRise  = sclNow & ~sclPrev;
    evt.sclFall  = ~sclNow & sclPrev;
    evt.startDet = sclNow & sclPrev & sdaPrev & ~sdaNow;
    evt.stopDet  = sclNow & sclPrev & ~sdaPrev & sdaNow;
    evt.sdaBit   = sdaNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxByte   <= '0;
      hiByte   <= '0;
      addrPtr  <= '0;
      regWdata <= '0;
      regWe    <= 1'b0;
      rdWord   <= '0;
    end else begin
      regWe <= strobe.commitWr;
      if (strobe.shiftEn)  rxByte  <= {rxByte[BYTE_W-2:0], sdaNow};
      if (strobe.latchHi)  hiByte  <= rxByte;
      if (strobe.commitWr) regWdata <= {hiByte, rxByte};
      if (strobe.loadAddr) addrPtr <= rxByte;
      else if (strobe.incAddr) addrPtr <= addrPtr + 1'b1;
      if (strobe.loadWord) rdWord <= regRdata;
    end
  end

  assign regAddr = addrPtr;
endmodule

// File: rtl/i2cRegCtrl.sv
module i2cRegCtrl
  import i2cRegPkg::*;
#(
  parameter logic [6:0] DEV_ID = 7'h1A
) (
  input  logic              clk,
  input  logic              rstN,
  input  busEvt_t           evt,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic [WORD_W-1:0] rdWord,
  input  logic [WORD_W-1:0] regRdata,
  output dpStrobe_t         strobe,
  output logic              sdaOe
);
  localparam logic [CNT_W-1:0] ACK_CNT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] END_CNT = CNT_W'(BYTE_W + 1);

  busState_e state;
  logic [CNT_W-1:0] bitCnt;
  logic rdMode, ackSeen, rxState, txState, devMatch;
  logic [BYTE_W-1:0] txByte;

  assign rxState  = (state == ST_DEV) || (state == ST_REG) ||
                    (state == ST_WHI) || (state == ST_WLO);
  assign txState  = (state == ST_RHI) || (state == ST_RLO);
  assign devMatch = (rxByte[BYTE_W-1:1] == DEV_ID);
  assign txByte   = (state == ST_RLO) ? rdWord[BYTE_W-1:0] : rdWord[WORD_W-1:BYTE_W];

  always_comb begin
    strobe          = '0;
    strobe.shiftEn  = evt.sclRise && rxState && (bitCnt < ACK_CNT);
    strobe.loadAddr = evt.sclFall && (bitCnt == ACK_CNT) && (state == ST_REG);
    strobe.latchHi  = evt.sclFall && (bitCnt == ACK_CNT) && (state == ST_WHI);
    strobe.commitWr = evt.sclFall && (bitCnt == ACK_CNT) && (state == ST_WLO);
    strobe.incAddr  = (evt.sclFall && (bitCnt == END_CNT) && (state == ST_WLO)) ||
                      (evt.sclRise && (bitCnt == ACK_CNT) && (state == ST_RLO) && !evt.sdaBit);
    strobe.loadWord = evt.sclFall && (bitCnt == END_CNT) &&
                      (((state == ST_DEV) && rdMode) || ((state == ST_RLO) && ackSeen));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      rdMode  <= 1'b0;
      ackSeen <= 1'b0;
      sdaOe   <= 1'b0;
    end else if (evt.startDet) begin
      state  <= ST_DEV;
      bitCnt <= '0;
      sdaOe  <= 1'b0;
    end else if (evt.stopDet) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      sdaOe  <= 1'b0;
    end else if (state != ST_IDLE && state != ST_SKIP) begin
      if (evt.sclRise) begin
        if (bitCnt == ACK_CNT) ackSeen <= ~evt.sdaBit;
        bitCnt <= bitCnt + 1'b1;
      end else if (evt.sclFall) begin
        if (bitCnt == ACK_CNT) begin
          if (txState) begin
            sdaOe <= 1'b0;
          end else if (state == ST_DEV && !devMatch) begin
            state <= ST_SKIP;
            sdaOe <= 1'b0;
          end else begin
            sdaOe <= 1'b1;
            if (state == ST_DEV) rdMode <= rxByte[0];
          end
        end else if (bitCnt == END_CNT) begin
          bitCnt <= '0;
          sdaOe  <= 1'b0;
          unique case (state)
            ST_DEV: begin
              state <= rdMode ? ST_RHI : ST_REG;
              if (rdMode) sdaOe <= ~regRdata[WORD_W-1];
            end
            ST_REG: state <= ST_WHI;
            ST_WHI: state <= ST_WLO;
            ST_WLO: state <= ST_WHI;
            ST_RHI: begin
              state <= ackSeen ? ST_RLO : ST_SKIP;
              if (ackSeen) sdaOe <= ~rdWord[BYTE_W-1];
            end
            ST_RLO: begin
              state <= ackSeen ? ST_RHI : ST_SKIP;
              if (ackSeen) sdaOe <= ~regRdata[WORD_W-1];
            end
            default: state <= ST_IDLE;
          endcase
        end else if (txState && bitCnt != '0) begin
          sdaOe <= ~txByte[3'(BYTE_W - 1) - bitCnt[2:0]];
        end
      end
    end
  end
endmodule

// File: rtl/i2cRegSlave.sv
module i2cRegSlave
  import i2cRegPkg::*;
#(
  parameter logic [6:0] DEV_ID      = 7'h1A,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  output logic        sdaOe,
  output logic [7:0]  regAddr,
  output logic [15:0] regWdata,
  output logic        regWe,
  input  logic [15:0] regRdata
);
  dpStrobe_t strobe;
  busEvt_t   evt;
  logic [BYTE_W-1:0] rxByte;
  logic [WORD_W-1:0] rdWord;

  i2cRegDatapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .strobe(strobe), .evt(evt), .rxByte(rxByte), .rdWord(rdWord),
    .regAddr(regAddr), .regWdata(regWdata), .regWe(regWe), .regRdata(regRdata)
  );

  i2cRegCtrl #(.DEV_ID(DEV_ID)) u_ctrl (
    .clk(clk), .rstN(rstN), .evt(evt), .rxByte(rxByte), .rdWord(rdWord),
    .regRdata(regRdata), .strobe(strobe), .sdaOe(sdaOe)
  );
endmodule

// File: rtl/i2cRegSlave_chk.sv
module i2cRegSlave_chk (
  input logic clk,
  input logic rstN,
  input logic sclIn,
  input logic sdaOe,
  input logic regWe,
  input logic startDet,
  input logic stopDet
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rstN |=> (!sdaOe && !regWe));

  // R9
  sda_change_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclIn);

  // R4
  commit_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWe |=> !regWe);

  // R4
  commit_acked_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWe |-> sdaOe);

  // R10
  stop_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> (!sdaOe && !regWe));

  // R10
  start_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> !sdaOe);
endmodule

bind i2cRegSlave i2cRegSlave_chk u_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaOe(sdaOe), .regWe(regWe),
  .startDet(evt.startDet), .stopDet(evt.stopDet)
);

// File: tb/i2cRegSlave_bench.sv
module i2cRegSlave_bench;
  localparam logic [6:0] ID = 7'h1A;
  localparam int HALF = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic sclM = 1'b1, sdaM = 1'b1;
  logic sdaOe, regWe, sdaBus;
  logic [7:0] regAddr;
  logic [15:0] regWdata, regRdata;
  logic [15:0] rf [256];
  int writeCnt = 0;
  int nChecks = 0, nFail = 0, glitchCnt = 0;
  logic prevOe = 1'b0;

  assign sdaBus = sdaM & ~sdaOe;
  assign regRdata = rf[regAddr];

  i2cRegSlave #(.DEV_ID(ID)) u_i2cRegSlave (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .sdaOe(sdaOe),
    .regAddr(regAddr), .regWdata(regWdata), .regWe(regWe), .regRdata(regRdata)
  );

  always @(posedge clk) begin
    if (regWe) begin
      rf[regAddr] <= regWdata;
      writeCnt <= writeCnt + 1;
    end
  end

  // R9 monitor: data drive must not move while the clock line is high
  always @(negedge clk) begin
    if (rstN && sdaOe != prevOe && sclM) glitchCnt <= glitchCnt + 1;
    prevOe <= sdaOe;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitClk(HALF);
    sclM = 1'b1; waitClk(HALF);
    sdaM = 1'b0; waitClk(HALF);
    sclM = 1'b0; waitClk(HALF);
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitClk(HALF);
    sclM = 1'b1; waitClk(HALF);
    sdaM = 1'b1; waitClk(HALF);
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdaM = b[i]; waitClk(HALF);
      sclM = 1'b1; waitClk(HALF);
      sclM = 1'b0;
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    sendBits(b, 8);
    sdaM = 1'b1; waitClk(HALF);
    sclM = 1'b1; waitClk(HALF / 2);
    acked = (sdaBus == 1'b0);
    waitClk(HALF / 2);
    sclM = 1'b0;
  endtask

  task automatic recvByte(input logic ackIt, output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitClk(HALF);
      sclM = 1'b1; waitClk(HALF / 2);
      b[i] = sdaBus;
      waitClk(HALF / 2);
      sclM = 1'b0;
    end
    sdaM = ackIt ? 1'b0 : 1'b1;
    waitClk(HALF);
    sclM = 1'b1; waitClk(HALF);
    sclM = 1'b0;
  endtask

  task automatic writeWords(input logic [7:0] idx, input logic [15:0] w0, w1, w2,
                            input int n, output logic allAck);
    logic a;
    logic [15:0] w;
    allAck = 1'b1;
    busStart();
    sendByte({ID, 1'b0}, a); allAck &= a;
    sendByte(idx, a); allAck &= a;
    for (int k = 0; k < n; k++) begin
      w = (k == 0) ? w0 : (k == 1) ? w1 : w2;
      sendByte(w[15:8], a); allAck &= a;
      sendByte(w[7:0], a); allAck &= a;
    end
    busStop();
  endtask

  task automatic readWords(input logic [7:0] idx, input bit setIdx, input int n,
                           output logic [15:0] r0, r1, r2, output logic allAck);
    logic a;
    logic [7:0] hi, lo;
    allAck = 1'b1;
    busStart();
    if (setIdx) begin
      sendByte({ID, 1'b0}, a); allAck &= a;
      sendByte(idx, a); allAck &= a;
      busStart();
    end
    sendByte({ID, 1'b1}, a); allAck &= a;
    r0 = '0; r1 = '0; r2 = '0;
    for (int k = 0; k < n; k++) begin
      recvByte(1'b1, hi);
      recvByte(k != n - 1, lo);
      if (k == 0) r0 = {hi, lo};
      else if (k == 1) r1 = {hi, lo};
      else r2 = {hi, lo};
    end
  endtask

  typedef struct packed {
    logic [7:0]  idx;
    logic [15:0] word;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{8'h00, 16'hA55A}, '{8'h7F, 16'h0001}, '{8'hC3, 16'h8000}, '{8'h13, 16'hFFFF}
  };

  bit done = 1'b0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    logic ok, a;
    logic [15:0] r0, r1, r2;
    int wc;
    logic [7:0] b;

    waitClk(5);
    // R1 reset state
    chk(sdaOe == 1'b0 && regWe == 1'b0, "R1 reset outputs", {sdaOe, regWe}, 0);
    rstN = 1'b1;
    waitClk(2);
    chk(regAddr == 8'h00, "R1 index after reset", regAddr, 8'h00);

    // vector table: single write, then single read-back
    for (int v = 0; v < 4; v++) begin
      wc = writeCnt;
      writeWords(VECS[v].idx, VECS[v].word, '0, '0, 1, ok);
      chk(ok, "R2 R3 R4 write acks", ok, 1);
      chk(writeCnt == wc + 1 && rf[VECS[v].idx] == VECS[v].word, "R4 committed word",
          rf[VECS[v].idx], VECS[v].word);
      readWords(VECS[v].idx, 1'b1, 1, r0, r1, r2, ok);
      busStop();
      chk(ok && r0 == VECS[v].word, "R7 read back", r0, VECS[v].word);
    end

    // R2 foreign identifier: no ack, no further drive, no write
    wc = writeCnt;
    busStart();
    sendByte({7'h2B, 1'b0}, a);
    chk(!a, "R2 foreign id not acked", a, 0);
    sendByte(8'h13, a);
    chk(!a, "R2 silent after foreign id", a, 0);
    sendByte(8'h55, a); sendByte(8'h66, a);
    busStop();
    chk(writeCnt == wc && rf[8'h13] == 16'hFFFF, "R2 no write after foreign id", rf[8'h13], 16'hFFFF);

    // R5 truncated write keeps old value
    writeWords(8'h40, 16'h1111, '0, '0, 1, ok);
    wc = writeCnt;
    busStart();
    sendByte({ID, 1'b0}, a); sendByte(8'h40, a); sendByte(8'hEE, a);
    busStop();
    chk(writeCnt == wc, "R5 no strobe on half word", writeCnt, wc);
    readWords(8'h40, 1'b1, 1, r0, r1, r2, ok);
    busStop();
    chk(r0 == 16'h1111, "R5 register unchanged", r0, 16'h1111);

    // R6 burst write with increment
    wc = writeCnt;
    writeWords(8'h20, 16'h0102, 16'h0304, 16'h0506, 3, ok);
    chk(ok && writeCnt == wc + 3, "R6 burst write count", writeCnt, wc + 3);
    chk(rf[8'h20] == 16'h0102 && rf[8'h21] == 16'h0304 && rf[8'h22] == 16'h0506,
        "R6 burst write contents", rf[8'h22], 16'h0506);
    chk(regAddr == 8'h23, "R6 index after burst", regAddr, 8'h23);

    // R6 wrap from 0xFF to 0x00
    writeWords(8'hFF, 16'hBEEF, 16'hCAFE, '0, 2, ok);
    chk(rf[8'hFF] == 16'hBEEF && rf[8'h00] == 16'hCAFE, "R6 wrap write", rf[8'h00], 16'hCAFE);

    // R8 burst read, last byte declined
    readWords(8'h20, 1'b1, 3, r0, r1, r2, ok);
    waitClk(HALF);
    chk(sdaOe == 1'b0, "R8 release after decline", sdaOe, 0);
    busStop();
    chk(ok && r0 == 16'h0102 && r1 == 16'h0304 && r2 == 16'h0506, "R8 burst read",
        r2, 16'h0506);
    chk(regAddr == 8'h22, "R8 index held after decline", regAddr, 8'h22);

    // R7 read without index byte uses leftover index
    readWords(8'h00, 1'b0, 1, r0, r1, r2, ok);
    busStop();
    chk(ok && r0 == 16'h0506, "R7 address-less read", r0, 16'h0506);

    // R10 repeated start in the middle of the index byte
    wc = writeCnt;
    busStart();
    sendByte({ID, 1'b0}, a);
    sendBits(8'hF0, 3);
    writeWords(8'h55, 16'h7E81, '0, '0, 1, ok);
    chk(ok && writeCnt == wc + 1 && rf[8'h55] == 16'h7E81, "R10 recovery after abort",
        rf[8'h55], 16'h7E81);

    // R10 stop in the middle of a data byte
    wc = writeCnt;
    busStart();
    sendByte({ID, 1'b0}, a); sendByte(8'h55, a); sendBits(8'h00, 5);
    sclM = 1'b0; sdaM = 1'b0; waitClk(HALF);
    busStop();
    readWords(8'h55, 1'b1, 1, r0, r1, r2, ok);
    busStop();
    chk(writeCnt == wc && r0 == 16'h7E81, "R10 stop drops partial byte", r0, 16'h7E81);

    // R9 no drive change while clock high
    chk(glitchCnt == 0, "R9 drive changes only with clock low", glitchCnt, 0);
    b = 8'h00;
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule